// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a free-running synchronous counter that walks a fixed, non-binary loop of five codes. It moves one step on each clock edge while its count enable is high. It has three state bits, and those bits are also the count value seen at the output. The loop order is 000, 010, 011, 101, 110 and then back to 000. Each state bit has its own next-state equation.

Three of the eight possible codes lie outside the loop: 001, 100 and 111. The counter is self-starting, so every one of these codes steps back into the loop within two enabled clocks. A power-up value or a flipped bit therefore cannot lock the counter up. A flag output is high while the present code is one of the three outside the loop.

A synchronous active-high reset takes priority over everything else and loads 000. While the enable is low, the present code is held. This is true even when the present code is outside the loop.

Top module: `seq5_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count_q` is 000 after that edge, whatever `cnt_en` is.
- R2: With `cnt_en` high and `rst` low, each rising edge moves `count_q` along the loop 000 → 010 → 011 → 101 → 110 → 000. Codes are written as bit 2, bit 1, bit 0.
- R3: With `cnt_en` low and `rst` low, `count_q` keeps its value across a clock edge. This holds for codes inside and outside the loop.
- R4: An enabled edge from code 001 leads to 110.
- R5: An enabled edge from code 100 leads to 010.
- R6: An enabled edge from code 111 leads to 100, and the next enabled edge leads to 010. Recovery from any code outside the loop takes at most two enabled edges.
- R7: `bad_code` is 1 exactly while `count_q` is 001, 100 or 111, and is 0 for the five loop codes.
- R8: Starting from any loop code, five enabled edges return `count_q` to the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| cnt_en | input | 1 | Step enable; when low, the code is held |
| count_q | output | 3 | Registered state code, which is also the count value |
| bad_code | output | 1 | High while the present code is outside the five-code loop |

## Verification
Reset and a low count enable can act in the same cycle. The bench provokes this by asserting `rst` while `cnt_en` is low, both with a loop code and with a code outside the loop held in the register. It judges the result by expecting 000 after the edge, which shows that reset wins over hold. The bench also places each code outside the loop into the register while reset is asserted. It then releases reset with the enable either high or low, to tell recovery apart from holding.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_S0 = 3'b000;
  localparam code_t CODE_S1 = 3'b010;
  localparam code_t CODE_S2 = 3'b011;
  localparam code_t CODE_S3 = 3'b101;
  localparam code_t CODE_S4 = 3'b110;

  localparam code_t CODE_X1 = 3'b001;
  localparam code_t CODE_X4 = 3'b100;
  localparam code_t CODE_X7 = 3'b111;

  localparam int HI_BIT  = 2;
  localparam int MID_BIT = 1;
  localparam int LO_BIT  = 0;
endpackage

// File: rtl/seq5_next.sv
module seq5_next
  import seq5_pkg::*;
(
  input  code_t cur_i,
  output code_t nxt_o
);
  logic hi_b, mid_b, lo_b;

  always_comb begin
    hi_b  = cur_i[HI_BIT];
    mid_b = cur_i[MID_BIT];
    lo_b  = cur_i[LO_BIT];
    nxt_o = '0;
    nxt_o[HI_BIT]  = lo_b;
    nxt_o[MID_BIT] = ~mid_b | (~lo_b & ~hi_b);
    nxt_o[LO_BIT]  = mid_b & ~hi_b;
  end
endmodule

// File: rtl/seq5_reg.sv
module seq5_reg
  import seq5_pkg::*;
#(
  parameter code_t INIT_CODE = CODE_S0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en_i,
  input  code_t d_i,
  output code_t q_o
);
  code_t state_q;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= INIT_CODE;
    else if (en_i)
      state_q <= d_i;
  end

  assign q_o = state_q;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(state_q));
endmodule

// File: rtl/seq5_decode.sv
module seq5_decode
  import seq5_pkg::*;
(
  input  code_t code_i,
  output logic  off_loop_o
);
  always_comb begin
    case (code_i)
      CODE_X1, CODE_X4, CODE_X7: off_loop_o = 1'b1;
      default:                   off_loop_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
  import seq5_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [2:0] count_q,
  output logic       bad_code
);
  code_t cur_code;
  code_t nxt_code;
  logic  off_loop;

  seq5_next u_next (
    .cur_i (cur_code),
    .nxt_o (nxt_code)
  );

  seq5_reg #(.INIT_CODE(CODE_S0)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .en_i (cnt_en),
    .d_i  (nxt_code),
    .q_o  (cur_code)
  );

  seq5_decode u_dec (
    .code_i     (cur_code),
    .off_loop_o (off_loop)
  );

  assign count_q  = cur_code;
  assign bad_code = off_loop;

  // R2
  step_s0_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_S0) |=> count_q == CODE_S1);
  // R2
  step_s1_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_S1) |=> count_q == CODE_S2);
  // R2
  step_s2_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_S2) |=> count_q == CODE_S3);
  // R2
  step_s3_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_S3) |=> count_q == CODE_S4);
  // R2
  step_s4_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_S4) |=> count_q == CODE_S0);
  // R4
  exit_x1_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_X1) |=> count_q == CODE_S4);
  // R5
  exit_x4_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_X4) |=> count_q == CODE_S1);
  // R6
  exit_x7_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == CODE_X7) |=> count_q == CODE_X4);
  // R7
  flag_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !bad_code) |=> !bad_code);
endmodule

// File: tb/test_seq5_counter.sv
module test_seq5_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] count_q;
  logic       bad_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  seq5_counter i_seq5_counter (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .count_q  (count_q),
    .bad_code (bad_code)
  );

  always #5 clk = ~clk;

  function automatic logic [2:0] loop_after(input logic [2:0] c);
    case (c)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      3'b110:  return 3'b000;
      3'b001:  return 3'b110;
      3'b100:  return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic off_loop(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b100) || (c == 3'b111);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic plant(input logic [2:0] c, input logic en_after);
    rst = 1'b1;
    tick();
    force i_seq5_counter.u_reg.state_q = c;
    #1;
    release i_seq5_counter.u_reg.state_q;
    rst    = 1'b0;
    cnt_en = en_after;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; cnt_en = 1'b1;
    tick(); tick();
    check("R1 reset with enable", count_q, 3'b000);
    check("R7 flag after reset", {2'b00, bad_code}, 3'b000);
    rst = 1'b0;
  endtask

  task automatic t_loop();
    logic [2:0] exp;
    exp = 3'b000;
    rst = 1'b1; tick(); rst = 1'b0; cnt_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick();
      exp = loop_after(exp);
      check("R2 loop step", count_q, exp);
      check("R7 flag in loop", {2'b00, bad_code}, 3'b000);
    end
  endtask

  task automatic t_hold();
    rst = 1'b1; tick(); rst = 1'b0; cnt_en = 1'b1;
    tick(); tick();
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 hold loop code", count_q, 3'b011);
    end
    plant(3'b111, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 hold off-loop code", count_q, 3'b111);
      check("R7 flag while held", {2'b00, bad_code}, 3'b001);
    end
    cnt_en = 1'b1;
    tick();
    check("R3 resume after hold", count_q, 3'b100);
  endtask

  task automatic t_recover();
    plant(3'b001, 1'b1);
    check("R7 flag on 001", {2'b00, bad_code}, 3'b001);
    tick();
    check("R4 001 exit", count_q, 3'b110);
    plant(3'b100, 1'b1);
    check("R7 flag on 100", {2'b00, bad_code}, 3'b001);
    tick();
    check("R5 100 exit", count_q, 3'b010);
    plant(3'b111, 1'b1);
    check("R7 flag on 111", {2'b00, bad_code}, 3'b001);
    tick();
    check("R6 111 first step", count_q, 3'b100);
    tick();
    check("R6 111 second step", count_q, 3'b010);
    check("R7 flag cleared", {2'b00, bad_code}, 3'b000);
  endtask

  task automatic t_period();
    logic [2:0] start;
    rst = 1'b1; tick(); rst = 1'b0; cnt_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      start = count_q;
      check("R7 loop code flag", {2'b00, bad_code}, {2'b00, off_loop(start)});
      for (int i = 0; i < 5; i++) tick();
      check("R8 period five", count_q, start);
      tick();
    end
  endtask

  task automatic t_reset_wins();
    rst = 1'b1; tick(); rst = 1'b0; cnt_en = 1'b1;
    tick(); tick(); tick();
    cnt_en = 1'b0; rst = 1'b1;
    tick();
    check("R1 reset over hold", count_q, 3'b000);
    plant(3'b111, 1'b0);
    rst = 1'b1;
    tick();
    check("R1 reset from off-loop code", count_q, 3'b000);
    check("R7 flag after reset", {2'b00, bad_code}, 3'b000);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_loop();
    t_hold();
    t_recover();
    t_period();
    t_reset_wins();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule